// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit integer pipeline and a data memory port that is one 32-bit word wide. For each memory request from the pipeline it adds a sign-extended 16-bit displacement to a 32-bit base value to form the byte address. It then checks that the address suits the access size. It issues a request for the aligned word that holds the addressed bytes. For stores it places the data on the correct byte lanes and drives a four-bit byte-enable mask.

When the memory answers a load, the unit picks the addressed byte or halfword out of the word, or merges part of the word into the old register value, and registers the result for one cycle. The left and right partial-word loads fetch only the one aligned word that holds the addressed byte. Used as a pair, they assemble an unaligned word.

A parameter fixes the byte numbering. With big-endian numbering, byte 0 of a word is its most significant byte. With little-endian numbering, byte 0 is its least significant byte. An illegal alignment does not trap. It raises `addr_err`, and no memory request is made.

Top module: `lsu_lane_align`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended to 32 bits. For every issued request, `mem_addr` equals that address with bits 1:0 forced to zero.
- R2: A full-word access (op 4 or op 10) whose byte address has bit 1 or bit 0 set raises `addr_err` and keeps `mem_req` low. A halfword access (op 2, 3 or 9) with address bit 0 set does the same. `addr_err` and `mem_req` are never high together.
- R3: With `BIG_ENDIAN`=1, byte offset 0 within a word is lane bits 31:24 and offset 3 is bits 7:0. With `BIG_ENDIAN`=0, offset 0 is bits 7:0 and offset 3 is bits 31:24. A halfword at offset k has the byte at offset k as its high byte in big-endian mode and as its low byte in little-endian mode.
- R4: Loads return: op 0 the addressed byte, sign-extended; op 1 that byte, zero-extended; op 2 the addressed halfword, sign-extended; op 3 that halfword, zero-extended; op 4 the whole word.
- R5: Stores assert `mem_we`. Op 10 drives all four enables with the store data unchanged. Op 8 drives exactly one enable, on the addressed lane, and repeats the low byte of the store data on all four lanes. Op 9 drives the two enables of the addressed halfword and repeats the low halfword on both halves. `mem_be` is zero when no store is issued.
- R6: Op 5 (left partial load) at offset k, big-endian: word bytes k..3 fill the register from its top byte down, and the low k bytes keep the old value. Little-endian: word bytes k..0 fill the top k+1 register bytes, and the low 3-k bytes keep the old value.
- R7: Op 6 (right partial load) at offset k, big-endian: word bytes 0..k fill the low k+1 register bytes, and the upper 3-k bytes keep the old value. Little-endian: word bytes k..3 fill the low 4-k register bytes, and the upper k bytes keep the old value.
- R8: Ops 5 and 6 never raise `addr_err`. They always issue exactly one request, for the aligned word holding the addressed byte.
- R9: If `mem_rvalid` is high in a cycle while an issued load is still unanswered, `load_valid` is high in the next cycle with the aligned result. `load_data` otherwise holds its value. A `mem_rvalid` with no unanswered load is ignored.
- R10: After reset, `load_valid` is 0, `load_data` is 0, and no load is outstanding.
- R11: Op codes 7 and 11 to 15 issue no request, raise no error and start no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Operation code (see R4 to R7, R11) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_store_data | input | 32 | Register value to store |
| req_old_value | input | 32 | Old destination register value for partial loads |
| mem_req | output | 1 | Memory access issued this cycle |
| mem_we | output | 1 | Issued access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane write enables, bit i covers bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rvalid | input | 1 | Memory read word is present |
| mem_rdata | input | 32 | Memory read word |
| addr_err | output | 1 | Alignment error for the current request |
| load_valid | output | 1 | Registered load result is valid |
| load_data | output | 32 | Registered load result |

## Verification
The bound checker watches every cycle for the following: issued addresses keep bits 1:0 clear and match the computed byte address; misaligned full-word accesses never reach memory; `addr_err` and `mem_req` stay exclusive; full-word stores enable all lanes and byte stores enable exactly one; partial loads never report errors; results appear only the cycle after a return; and `load_data` holds between results. The choice of lane and the merge with the old register value differ between byte orders and byte offsets, so only the bench's scenarios can show them. The bench runs both orderings side by side against hand-worked expected words. It also covers negative displacements, stray memory returns and unused op codes.

// File: rtl/lsu_lane_pkg.sv
`timescale 1ns/1ps
package lsu_lane_pkg;

    localparam int BYTE_W     = 8;
    localparam int LANES      = 4;
    localparam int WORD_W     = BYTE_W * LANES;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int HALF_W     = 2 * BYTE_W;
    localparam int OP_W       = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LB  = 4'd0,
        OP_LBU = 4'd1,
        OP_LH  = 4'd2,
        OP_LHU = 4'd3,
        OP_LW  = 4'd4,
        OP_LWL = 4'd5,
        OP_LWR = 4'd6,
        OP_SB  = 4'd8,
        OP_SH  = 4'd9,
        OP_SW  = 4'd10
    } lsu_op_e;

    // Registered state of the unit: pending-load context plus result stage
    typedef struct packed {
        logic                  pend;
        logic [OP_W-1:0]       op;
        logic [LANE_IDX_W-1:0] ofs;
        logic [WORD_W-1:0]     old;
        logic                  vld;
        logic [WORD_W-1:0]     data;
    } lsu_state_t;

endpackage

// File: rtl/lsu_ea_check.sv
`timescale 1ns/1ps
module lsu_ea_check
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0]     base,
    input  logic [OFF_W-1:0]      offset,
    input  logic [OP_W-1:0]       op,
    output logic [ADDR_W-1:0]     ea,
    output logic [LANE_IDX_W-1:0] byte_ofs,
    output logic                  legal,
    output logic                  is_store,
    output logic                  misaligned
);
    localparam int EXT_W = ADDR_W - OFF_W;

    always_comb begin
        ea         = base + {{EXT_W{offset[OFF_W-1]}}, offset};
        byte_ofs   = ea[LANE_IDX_W-1:0];
        legal      = 1'b1;
        is_store   = 1'b0;
        misaligned = 1'b0;
        case (op)
            OP_LW:          misaligned = |ea[LANE_IDX_W-1:0];
            OP_SW: begin
                            misaligned = |ea[LANE_IDX_W-1:0];
                            is_store   = 1'b1;
            end
            OP_LH, OP_LHU:  misaligned = ea[0];
            OP_SH: begin
                            misaligned = ea[0];
                            is_store   = 1'b1;
            end
            OP_SB:          is_store   = 1'b1;
            OP_LB, OP_LBU, OP_LWL, OP_LWR: misaligned = 1'b0;
            default:        legal      = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
`timescale 1ns/1ps
module lsu_store_lanes
    import lsu_lane_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [OP_W-1:0]       op,
    input  logic [LANE_IDX_W-1:0] byte_ofs,
    input  logic [WORD_W-1:0]     store_data,
    output logic [LANES-1:0]      be,
    output logic [WORD_W-1:0]     wdata
);
    localparam int HALVES = LANES / 2;

    logic [LANE_IDX_W-1:0] byte_lane;
    logic [LANE_IDX_W-1:0] half_lane;

    generate
        if (BIG_ENDIAN) begin : g_big
            assign byte_lane = ~byte_ofs;
            assign half_lane = {~byte_ofs[LANE_IDX_W-1], 1'b0};
        end else begin : g_little
            assign byte_lane = byte_ofs;
            assign half_lane = {byte_ofs[LANE_IDX_W-1], 1'b0};
        end
    endgenerate

    always_comb begin
        be    = '0;
        wdata = store_data;
        case (op)
            OP_SB: begin
                be    = LANES'(1) << byte_lane;
                wdata = {LANES{store_data[BYTE_W-1:0]}};
            end
            OP_SH: begin
                be    = LANES'(3) << half_lane;
                wdata = {HALVES{store_data[HALF_W-1:0]}};
            end
            OP_SW: begin
                be    = '1;
                wdata = store_data;
            end
            default: be = '0;
        endcase
    end
endmodule

// File: rtl/lsu_load_align.sv
`timescale 1ns/1ps
module lsu_load_align
    import lsu_lane_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [OP_W-1:0]       op,
    input  logic [LANE_IDX_W-1:0] byte_ofs,
    input  logic [WORD_W-1:0]     word,
    input  logic [WORD_W-1:0]     old_value,
    output logic [WORD_W-1:0]     result
);
    localparam int SH_W = LANE_IDX_W + 3;
    localparam logic [WORD_W-1:0] ONES = '1;

    logic [LANE_IDX_W-1:0] byte_lane;
    logic [LANE_IDX_W-1:0] half_lane;
    logic [LANE_IDX_W-1:0] left_sh;
    logic [LANE_IDX_W-1:0] right_sh;

    generate
        if (BIG_ENDIAN) begin : g_big
            assign byte_lane = ~byte_ofs;
            assign half_lane = {~byte_ofs[LANE_IDX_W-1], 1'b0};
            assign left_sh   = byte_ofs;
        end else begin : g_little
            assign byte_lane = byte_ofs;
            assign half_lane = {byte_ofs[LANE_IDX_W-1], 1'b0};
            assign left_sh   = ~byte_ofs;
        end
    endgenerate

    assign right_sh = ~left_sh;

    logic [BYTE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic [SH_W-1:0]   lsh_bits;
    logic [SH_W-1:0]   rsh_bits;
    logic [WORD_W-1:0] left_merge;
    logic [WORD_W-1:0] right_merge;

    always_comb begin
        sel_byte    = word[{byte_lane, 3'b000} +: BYTE_W];
        sel_half    = word[{half_lane, 3'b000} +: HALF_W];
        lsh_bits    = {left_sh, 3'b000};
        rsh_bits    = {right_sh, 3'b000};
        left_merge  = (word << lsh_bits) | (old_value & ~(ONES << lsh_bits));
        right_merge = (word >> rsh_bits) | (old_value & ~(ONES >> rsh_bits));
        case (op)
            OP_LB:   result = {{(WORD_W-BYTE_W){sel_byte[BYTE_W-1]}}, sel_byte};
            OP_LBU:  result = {{(WORD_W-BYTE_W){1'b0}}, sel_byte};
            OP_LH:   result = {{(WORD_W-HALF_W){sel_half[HALF_W-1]}}, sel_half};
            OP_LHU:  result = {{(WORD_W-HALF_W){1'b0}}, sel_half};
            OP_LWL:  result = left_merge;
            OP_LWR:  result = right_merge;
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
`timescale 1ns/1ps
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1,
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [OP_W-1:0]      req_op,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [WORD_W-1:0]    req_store_data,
    input  logic [WORD_W-1:0]    req_old_value,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LANES-1:0]     mem_be,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 addr_err,
    output logic                 load_valid,
    output logic [WORD_W-1:0]    load_data
);
    logic [ADDR_W-1:0]     ea;
    logic [LANE_IDX_W-1:0] byte_ofs;
    logic                  legal;
    logic                  is_store;
    logic                  misaligned;
    logic [LANES-1:0]      be_c;
    logic [WORD_W-1:0]     wdata_c;
    logic [WORD_W-1:0]     aligned_c;
    logic                  issue;

    lsu_state_t st_d, st_q;

    lsu_ea_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
        .base       (req_base),
        .offset     (req_offset),
        .op         (req_op),
        .ea         (ea),
        .byte_ofs   (byte_ofs),
        .legal      (legal),
        .is_store   (is_store),
        .misaligned (misaligned)
    );

    lsu_store_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_st (
        .op         (req_op),
        .byte_ofs   (byte_ofs),
        .store_data (req_store_data),
        .be         (be_c),
        .wdata      (wdata_c)
    );

    // Aligns the returned word using the context captured at issue time
    lsu_load_align #(.BIG_ENDIAN(BIG_ENDIAN)) u_ld (
        .op        (st_q.op),
        .byte_ofs  (st_q.ofs),
        .word      (mem_rdata),
        .old_value (st_q.old),
        .result    (aligned_c)
    );

    always_comb begin
        issue     = req_valid && legal && !misaligned;
        mem_req   = issue;
        mem_we    = issue && is_store;
        mem_addr  = {ea[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};
        mem_be    = (issue && is_store) ? be_c : '0;
        mem_wdata = wdata_c;
        addr_err  = req_valid && legal && misaligned;

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (mem_rvalid && st_q.pend) begin
            st_d.vld  = 1'b1;
            st_d.data = aligned_c;
            st_d.pend = 1'b0;
        end
        if (issue && !is_store) begin
            st_d.pend = 1'b1;
            st_d.op   = req_op;
            st_d.ofs  = byte_ofs;
            st_d.old  = req_old_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_valid = st_q.vld;
    assign load_data  = st_q.data;

endmodule

// File: rtl/lsu_lane_align_chk.sv
`timescale 1ns/1ps
module lsu_lane_align_chk
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OP_W-1:0]   req_op,
    input logic [ADDR_W-1:0] req_base,
    input logic [OFF_W-1:0]  req_offset,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic              mem_rvalid,
    input logic              addr_err,
    input logic              load_valid,
    input logic [WORD_W-1:0] load_data
);
    logic [ADDR_W-1:0] byte_addr;
    assign byte_addr = req_base + {{(ADDR_W-OFF_W){req_offset[OFF_W-1]}}, req_offset};

    assert_word_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LANE_IDX_W-1:0] == '0) &&
                    (mem_addr[ADDR_W-1:LANE_IDX_W] == byte_addr[ADDR_W-1:LANE_IDX_W]));

    assert_word_misalign_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_LW || req_op == OP_SW) && (byte_addr[LANE_IDX_W-1:0] != '0))
        |-> (!mem_req && addr_err));

    assert_err_excludes_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !mem_req);

    assert_word_store_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_op == OP_SW) |-> (mem_we && mem_be == '1));

    assert_byte_store_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_op == OP_SB) |-> ($countones(mem_be) == 1));

    assert_partial_no_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_LWL || req_op == OP_LWR)) |-> (mem_req && !addr_err && !mem_we));

    assert_result_follows_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(mem_rvalid));

    assert_result_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> $stable(load_data));

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_base   (req_base),
    .req_offset (req_offset),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_rvalid (mem_rvalid),
    .addr_err   (addr_err),
    .load_valid (load_valid),
    .load_data  (load_data)
);

// File: tb/lsu_lane_align_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_align_tb_top;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] aux;
        logic [31:0] rdata;
        logic [3:0]  be_b;
        logic [3:0]  be_l;
        logic [31:0] exp_b;
        logic [31:0] exp_l;
        logic        err;
    } vec_t;

    localparam logic [31:0] W = 32'h11223344;
    localparam logic [31:0] O = 32'hAABBCCDD;
    localparam logic [31:0] S = 32'h55667788;
    localparam int NV = 23;

    localparam vec_t VECS [NV] = '{
        '{4'd4,  32'h1000, 16'h0004, O, W,            4'h0, 4'h0, 32'h11223344, 32'h11223344, 1'b0},
        '{4'd0,  32'h3000, 16'hFFFF, O, 32'h8091A2B3, 4'h0, 4'h0, 32'hFFFFFFB3, 32'hFFFFFF80, 1'b0},
        '{4'd1,  32'h3000, 16'hFFFF, O, 32'h8091A2B3, 4'h0, 4'h0, 32'h000000B3, 32'h00000080, 1'b0},
        '{4'd0,  32'h2000, 16'h0001, O, W,            4'h0, 4'h0, 32'h00000022, 32'h00000033, 1'b0},
        '{4'd2,  32'h2000, 16'h0002, O, 32'h1122F344, 4'h0, 4'h0, 32'hFFFFF344, 32'h00001122, 1'b0},
        '{4'd3,  32'h2000, 16'h0000, O, 32'h8899AABB, 4'h0, 4'h0, 32'h00008899, 32'h0000AABB, 1'b0},
        '{4'd5,  32'h4000, 16'h0001, O, W,            4'h0, 4'h0, 32'h223344DD, 32'h3344CCDD, 1'b0},
        '{4'd5,  32'h4000, 16'h0003, O, W,            4'h0, 4'h0, 32'h44BBCCDD, 32'h11223344, 1'b0},
        '{4'd5,  32'h4000, 16'h0000, O, W,            4'h0, 4'h0, 32'h11223344, 32'h44BBCCDD, 1'b0},
        '{4'd6,  32'h4000, 16'h0001, O, W,            4'h0, 4'h0, 32'hAABB1122, 32'hAA112233, 1'b0},
        '{4'd6,  32'h4000, 16'h0003, O, W,            4'h0, 4'h0, 32'h11223344, 32'hAABBCC11, 1'b0},
        '{4'd6,  32'h4000, 16'h0000, O, W,            4'h0, 4'h0, 32'hAABBCC11, 32'h11223344, 1'b0},
        '{4'd10, 32'h5000, 16'h0008, S, 32'h0,        4'hF, 4'hF, 32'h55667788, 32'h55667788, 1'b0},
        '{4'd8,  32'h5000, 16'h0001, S, 32'h0,        4'h4, 4'h2, 32'h88888888, 32'h88888888, 1'b0},
        '{4'd8,  32'h5000, 16'h0003, S, 32'h0,        4'h1, 4'h8, 32'h88888888, 32'h88888888, 1'b0},
        '{4'd9,  32'h5000, 16'h0002, S, 32'h0,        4'h3, 4'hC, 32'h77887788, 32'h77887788, 1'b0},
        '{4'd9,  32'h5000, 16'h0000, S, 32'h0,        4'hC, 4'h3, 32'h77887788, 32'h77887788, 1'b0},
        '{4'd4,  32'h6000, 16'h0002, O, W,            4'h0, 4'h0, 32'h0,        32'h0,        1'b1},
        '{4'd10, 32'h6000, 16'h0001, S, W,            4'h0, 4'h0, 32'h0,        32'h0,        1'b1},
        '{4'd2,  32'h6000, 16'h0003, O, W,            4'h0, 4'h0, 32'h0,        32'h0,        1'b1},
        '{4'd9,  32'h6000, 16'h0001, S, W,            4'h0, 4'h0, 32'h0,        32'h0,        1'b1},
        '{4'd4,  32'h6003, 16'h0001, O, 32'hDEADBEEF, 4'h0, 4'h0, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0},
        '{4'd3,  32'h2000, 16'hFFFE, O, 32'h1122F344, 4'h0, 4'h0, 32'h0000F344, 32'h00001122, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_store_data = '0;
    logic [31:0] req_old_value = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic        mem_req_b, mem_we_b, addr_err_b, load_valid_b;
    logic [31:0] mem_addr_b, mem_wdata_b, load_data_b;
    logic [3:0]  mem_be_b;
    logic        mem_req_l, mem_we_l, addr_err_l, load_valid_l;
    logic [31:0] mem_addr_l, mem_wdata_l, load_data_l;
    logic [3:0]  mem_be_l;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lsu_lane_align #(.BIG_ENDIAN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_store_data(req_store_data),
        .req_old_value(req_old_value), .mem_req(mem_req_b), .mem_we(mem_we_b),
        .mem_addr(mem_addr_b), .mem_be(mem_be_b), .mem_wdata(mem_wdata_b),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .addr_err(addr_err_b),
        .load_valid(load_valid_b), .load_data(load_data_b)
    );

    lsu_lane_align #(.BIG_ENDIAN(1'b0)) dut_le_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_store_data(req_store_data),
        .req_old_value(req_old_value), .mem_req(mem_req_l), .mem_we(mem_we_l),
        .mem_addr(mem_addr_l), .mem_be(mem_be_l), .mem_wdata(mem_wdata_l),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .addr_err(addr_err_l),
        .load_valid(load_valid_l), .load_data(load_data_l)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd5:                tag_of = "R6 LWL";
            4'd6:                tag_of = "R7 LWR";
            4'd8, 4'd9, 4'd10:   tag_of = "R5 store";
            default:             tag_of = "R3 R4 load";
        endcase
    endfunction

    task automatic run_vec(input int idx, input vec_t v);
        logic [31:0] ea;
        logic [31:0] exp_addr;
        bit          is_st;
        ea       = v.base + {{16{v.off[15]}}, v.off};
        exp_addr = {ea[31:2], 2'b00};
        is_st    = (v.op >= 4'd8);
        @(negedge clk);
        req_valid      = 1'b1;
        req_op         = v.op;
        req_base       = v.base;
        req_offset     = v.off;
        req_store_data = v.aux;
        req_old_value  = v.aux;
        #2;
        if (v.err) begin
            chk($sformatf("R2 err/req big vec%0d", idx), {30'd0, addr_err_b, mem_req_b}, 32'd2);
            chk($sformatf("R2 err/req little vec%0d", idx), {30'd0, addr_err_l, mem_req_l}, 32'd2);
        end else begin
            chk($sformatf("R1 addr big vec%0d", idx), mem_addr_b, exp_addr);
            chk($sformatf("R1 addr little vec%0d", idx), mem_addr_l, exp_addr);
            chk($sformatf("R8 req/err/we big vec%0d", idx),
                {29'd0, mem_req_b, addr_err_b, mem_we_b}, {29'd0, 1'b1, 1'b0, is_st});
            chk($sformatf("R8 req/err/we little vec%0d", idx),
                {29'd0, mem_req_l, addr_err_l, mem_we_l}, {29'd0, 1'b1, 1'b0, is_st});
            if (is_st) begin
                chk($sformatf("R5 R3 be big vec%0d", idx), {28'd0, mem_be_b}, {28'd0, v.be_b});
                chk($sformatf("R5 R3 be little vec%0d", idx), {28'd0, mem_be_l}, {28'd0, v.be_l});
                chk($sformatf("R5 wdata big vec%0d", idx), mem_wdata_b, v.exp_b);
                chk($sformatf("R5 wdata little vec%0d", idx), mem_wdata_l, v.exp_l);
            end
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!v.err && !is_st) begin
            mem_rvalid = 1'b1;
            mem_rdata  = v.rdata;
            @(posedge clk);
            @(negedge clk);
            mem_rvalid = 1'b0;
            #2;
            chk($sformatf("R9 load_valid big vec%0d", idx), {31'd0, load_valid_b}, 32'd1);
            chk($sformatf("R9 load_valid little vec%0d", idx), {31'd0, load_valid_l}, 32'd1);
            chk($sformatf("%s big vec%0d", tag_of(v.op), idx), load_data_b, v.exp_b);
            chk($sformatf("%s little vec%0d", tag_of(v.op), idx), load_data_l, v.exp_l);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired, run hung");
            finish_run();
        end
    end

    initial begin
        logic [31:0] last_b;
        logic [31:0] last_l;
        repeat (3) @(negedge clk);
        #2;
        // R10: reset state
        chk("R10 load_valid big", {31'd0, load_valid_b}, 32'd0);
        chk("R10 load_data big", load_data_b, 32'd0);
        chk("R10 load_data little", load_data_l, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: no load outstanding after reset, so a return is ignored
        mem_rvalid = 1'b1;
        mem_rdata  = 32'hCAFEF00D;
        @(negedge clk);
        mem_rvalid = 1'b0;
        #2;
        chk("R10 R9 no pending after reset", {30'd0, load_valid_b, load_valid_l}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R9: result holds and valid drops in the following cycle
        last_b = load_data_b;
        last_l = load_data_l;
        @(negedge clk);
        #2;
        chk("R9 valid pulse one cycle", {30'd0, load_valid_b, load_valid_l}, 32'd0);
        chk("R9 hold big", load_data_b, 32'h0000F344);
        chk("R9 hold little", load_data_l, 32'h00001122);

        // R9: stray return after a store is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd10; req_base = 32'h7000; req_offset = 16'h0;
        @(negedge clk);
        req_valid  = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = 32'hFFFFFFFF;
        @(negedge clk);
        mem_rvalid = 1'b0;
        #2;
        chk("R9 stray return valid", {30'd0, load_valid_b, load_valid_l}, 32'd0);
        chk("R9 stray return data big", load_data_b, last_b);
        chk("R9 stray return data little", load_data_l, last_l);

        // R11: unused op codes
        foreach (VECS[j]) begin end
        for (int u = 0; u < 6; u++) begin
            @(negedge clk);
            req_valid  = 1'b1;
            req_op     = (u == 0) ? 4'd7 : 4'(10 + u);
            req_base   = 32'h8001;
            req_offset = 16'h0001;
            #2;
            chk($sformatf("R11 op %0d req/err big", req_op),
                {30'd0, mem_req_b, addr_err_b}, 32'd0);
            chk($sformatf("R11 op %0d req/err little", req_op),
                {30'd0, mem_req_l, addr_err_l}, 32'd0);
        end
        @(negedge clk);
        req_valid  = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = 32'h12345678;
        @(negedge clk);
        mem_rvalid = 1'b0;
        #2;
        chk("R11 no load started", {30'd0, load_valid_b, load_valid_l}, 32'd0);
        chk("R11 data unchanged big", load_data_b, last_b);

        // R8: left partial at the top offset of a negative-displacement word
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd5; req_base = 32'h9000; req_offset = 16'hFFFE;
        req_old_value = O;
        #2;
        chk("R8 partial addr big", mem_addr_b, 32'h00008FFC);
        chk("R8 partial no err little", {30'd0, mem_req_l, addr_err_l}, 32'd2);
        @(negedge clk);
        req_valid  = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = W;
        @(negedge clk);
        mem_rvalid = 1'b0;
        #2;
        chk("R6 LWL ofs2 big", load_data_b, 32'h3344CCDD);
        chk("R6 LWL ofs2 little", load_data_l, 32'h223344DD);

        finish_run();
    end

endmodule